// File: doc/BRIEF.md
# Cross-Domain Mailbox Pair

This block carries single 32-bit words between two ports that run on unrelated clocks. It bypasses any queue. There is one mailbox for each direction. The A-to-B mailbox is written from port A and read at port B. The B-to-A mailbox is written from port B and read at port A.

Each port has a control group: chip select, a write/read choice, an enable and a mailbox select. A write on a port with mailbox select high stores the port's input word, as long as that direction's mailbox is empty. The word then stays put until the far side takes it. Each mailbox has an active-low flag in both clock domains:
- The writer's copy tells the writer that a letter is still unread, and it blocks further writes.
- The reader's copy tells the reader that mail is waiting.

Set and clear events cross the domains as toggles through two-flop synchronizers.

Top module: `dual_mailbox`

## Requirements
- R1: While a port's synchronous reset is high (both resets are asserted together), every flag of that port is high (idle) and its read data output is all zeros.
- R2: A rising edge of the writer clock with cs=1, wr=1, en=1, mbx=1 while the writer flag is high stores the input word and drives the writer flag low at that same edge.
- R3: A mailbox write attempted while the writer flag is low is ignored: the stored word and both flags are unchanged.
- R4: A write with any of cs, en or mbx low stores nothing and leaves both flags high.
- R5: After a storing edge, the reader flag goes low by the fourth reader clock edge. It then stays low until a take (R6).
- R6: A take is a reader-clock edge with cs=1, wr=0, en=1, mbx=1 while the reader flag is low. On that edge the reader flag goes high and the stored word appears on read data. The writer flag returns high within four writer clock edges, and the next write can then be stored.
- R7: On every reader clock edge, read data is updated. It becomes the stored word when cs=1, wr=0, mbx=1, whatever en is. It becomes zero otherwise. A view with en=0 does not consume the mail.
- R8: A take attempted while the reader flag is high has no effect on either flag.
- R9: The two directions are independent. Traffic in one direction never changes the flags or data of the other direction.
- R10: While the reader flag is low, the stored word does not change. Consecutive views return the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Port A synchronous reset, active high |
| a_cs | input | 1 | Port A select |
| a_wr | input | 1 | Port A: 1 = write, 0 = read |
| a_en | input | 1 | Port A enable |
| a_mbx | input | 1 | Port A mailbox select |
| a_wdata | input | DATA_W | Word written into the A-to-B mailbox |
| a_rdata | output | DATA_W | B-to-A mailbox word when viewed, else zero |
| a_ab_flag_n | output | 1 | A-to-B mail unread (low), port A copy |
| a_ba_flag_n | output | 1 | B-to-A mail waiting (low), port A copy |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Port B synchronous reset, active high |
| b_cs | input | 1 | Port B select |
| b_wr | input | 1 | Port B: 1 = write, 0 = read |
| b_en | input | 1 | Port B enable |
| b_mbx | input | 1 | Port B mailbox select |
| b_wdata | input | DATA_W | Word written into the B-to-A mailbox |
| b_rdata | output | DATA_W | A-to-B mailbox word when viewed, else zero |
| b_ab_flag_n | output | 1 | A-to-B mail waiting (low), port B copy |
| b_ba_flag_n | output | 1 | B-to-A mail unread (low), port B copy |

## Verification
The hardest state to reach is a write that arrives while the previous letter is still unread, on the same side that has not yet seen the clear. The stimulus creates it by storing one word and then writing a second word before port B takes anything. It also views the mailbox without enable, and reads with the mailbox select low, so the pending state lasts across several reader cycles. Taking the mail must then return the first word. A streaming phase pushes words back to back, so every write waits for the clear to cross back into the writer domain.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  typedef struct packed {
    logic cs;
    logic wr;
    logic en;
    logic mbx;
  } port_ctl_t;

  function automatic logic mail_store(port_ctl_t c);
    return c.cs & c.wr & c.en & c.mbx;
  endfunction

  function automatic logic mail_take(port_ctl_t c);
    return c.cs & ~c.wr & c.en & c.mbx;
  endfunction

  function automatic logic mail_view(port_ctl_t c);
    return c.cs & ~c.wr & c.mbx;
  endfunction

endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-2:0], d};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= d;
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/mbox_send.sv
module mbox_send
  import mbox_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  port_ctl_t         ctl,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clr_tgl,
  output logic              set_tgl,
  output logic [DATA_W-1:0] data_q,
  output logic              flag_n
);
  logic clr_sync;
  logic store;
  logic set_nxt;

  mbox_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
    .clk (clk),
    .rst (rst),
    .d   (clr_tgl),
    .q   (clr_sync)
  );

  // A store is accepted only while the writer copy reports an empty box.
  assign store   = mail_store(ctl) & flag_n;
  assign set_nxt = set_tgl ^ store;

  always_ff @(posedge clk) begin
    if (rst) begin
      set_tgl <= 1'b0;
      flag_n  <= 1'b1;
      data_q  <= '0;
    end else begin
      set_tgl <= set_nxt;
      flag_n  <= ~(set_nxt ^ clr_sync);
      if (store) data_q <= wdata;
    end
  end
endmodule

// File: rtl/mbox_recv.sv
module mbox_recv
  import mbox_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  port_ctl_t         ctl,
  input  logic              set_tgl,
  input  logic [DATA_W-1:0] mail_data,
  output logic              clr_tgl,
  output logic              flag_n,
  output logic [DATA_W-1:0] rdata
);
  logic set_sync;
  logic take;
  logic clr_nxt;

  mbox_sync #(.STAGES(SYNC_STAGES)) u_set_sync (
    .clk (clk),
    .rst (rst),
    .d   (set_tgl),
    .q   (set_sync)
  );

  // Only a take against pending mail flips the clear toggle.
  assign take    = mail_take(ctl) & ~flag_n;
  assign clr_nxt = clr_tgl ^ take;

  always_ff @(posedge clk) begin
    if (rst) begin
      clr_tgl <= 1'b0;
      flag_n  <= 1'b1;
      rdata   <= '0;
    end else begin
      clr_tgl <= clr_nxt;
      flag_n  <= ~(set_sync ^ clr_nxt);
      rdata   <= mail_view(ctl) ? mail_data : '0;
    end
  end
endmodule

// File: rtl/mbox_channel.sv
module mbox_channel
  import mbox_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  port_ctl_t         wr_ctl,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_flag_n,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  port_ctl_t         rd_ctl,
  output logic              rd_flag_n,
  output logic [DATA_W-1:0] rd_data
);
  logic              set_tgl;
  logic              clr_tgl;
  logic [DATA_W-1:0] mail_q;

  mbox_send #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_send (
    .clk     (wr_clk),
    .rst     (wr_rst),
    .ctl     (wr_ctl),
    .wdata   (wr_data),
    .clr_tgl (clr_tgl),
    .set_tgl (set_tgl),
    .data_q  (mail_q),
    .flag_n  (wr_flag_n)
  );

  mbox_recv #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_recv (
    .clk       (rd_clk),
    .rst       (rd_rst),
    .ctl       (rd_ctl),
    .set_tgl   (set_tgl),
    .mail_data (mail_q),
    .clr_tgl   (clr_tgl),
    .flag_n    (rd_flag_n),
    .rdata     (rd_data)
  );
endmodule

// File: rtl/dual_mailbox.sv
module dual_mailbox
  import mbox_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_a,
  input  logic              rst_a,
  input  logic              a_cs,
  input  logic              a_wr,
  input  logic              a_en,
  input  logic              a_mbx,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_ab_flag_n,
  output logic              a_ba_flag_n,
  input  logic              clk_b,
  input  logic              rst_b,
  input  logic              b_cs,
  input  logic              b_wr,
  input  logic              b_en,
  input  logic              b_mbx,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_ab_flag_n,
  output logic              b_ba_flag_n
);
  port_ctl_t a_ctl;
  port_ctl_t b_ctl;

  assign a_ctl = '{cs: a_cs, wr: a_wr, en: a_en, mbx: a_mbx};
  assign b_ctl = '{cs: b_cs, wr: b_wr, en: b_en, mbx: b_mbx};

  // A writes, B reads
  mbox_channel #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ab (
    .wr_clk    (clk_a),
    .wr_rst    (rst_a),
    .wr_ctl    (a_ctl),
    .wr_data   (a_wdata),
    .wr_flag_n (a_ab_flag_n),
    .rd_clk    (clk_b),
    .rd_rst    (rst_b),
    .rd_ctl    (b_ctl),
    .rd_flag_n (b_ab_flag_n),
    .rd_data   (b_rdata)
  );

  // B writes, A reads
  mbox_channel #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ba (
    .wr_clk    (clk_b),
    .wr_rst    (rst_b),
    .wr_ctl    (b_ctl),
    .wr_data   (b_wdata),
    .wr_flag_n (b_ba_flag_n),
    .rd_clk    (clk_a),
    .rd_rst    (rst_a),
    .rd_ctl    (a_ctl),
    .rd_flag_n (a_ba_flag_n),
    .rd_data   (a_rdata)
  );
endmodule

// File: rtl/dual_mailbox_chk.sv
module dual_mailbox_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_a,
  input logic              rst_a,
  input logic              a_cs,
  input logic              a_wr,
  input logic              a_en,
  input logic              a_mbx,
  input logic [DATA_W-1:0] a_rdata,
  input logic              a_ab_flag_n,
  input logic              a_ba_flag_n,
  input logic              clk_b,
  input logic              rst_b,
  input logic              b_cs,
  input logic              b_wr,
  input logic              b_en,
  input logic              b_mbx,
  input logic [DATA_W-1:0] b_rdata,
  input logic              b_ab_flag_n,
  input logic              b_ba_flag_n
);
  logic a_store_try;
  logic b_take_try;
  logic b_view;
  logic b_pend_view;

  assign a_store_try = a_cs & a_wr & a_en & a_mbx;
  assign b_take_try  = b_cs & ~b_wr & b_en & b_mbx;
  assign b_view      = b_cs & ~b_wr & b_mbx;
  assign b_pend_view = b_view & ~b_en & ~b_ab_flag_n;

  AST_RESET_IDLE_A: assert property (@(posedge clk_a)
    rst_a |=> (a_ab_flag_n && a_ba_flag_n && a_rdata == '0)); // R1
  AST_RESET_IDLE_B: assert property (@(posedge clk_b)
    rst_b |=> (b_ab_flag_n && b_ba_flag_n && b_rdata == '0)); // R1
  AST_STORE_SETS_FLAG: assert property (@(posedge clk_a) disable iff (rst_a)
    (a_store_try && a_ab_flag_n) |=> !a_ab_flag_n); // R2
  AST_PENDING_HOLDS: assert property (@(posedge clk_b) disable iff (rst_b)
    (!b_ab_flag_n && !b_take_try) |=> !b_ab_flag_n); // R5
  AST_TAKE_CLEARS: assert property (@(posedge clk_b) disable iff (rst_b)
    (b_take_try && !b_ab_flag_n) |=> b_ab_flag_n); // R6
  AST_NO_VIEW_ZERO: assert property (@(posedge clk_b) disable iff (rst_b)
    !b_view |=> (b_rdata == '0)); // R7
  AST_DATA_STABLE: assert property (@(posedge clk_b) disable iff (rst_b)
    ($past(b_pend_view) && b_pend_view) |=> $stable(b_rdata)); // R10
endmodule

bind dual_mailbox dual_mailbox_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_a       (clk_a),
  .rst_a       (rst_a),
  .a_cs        (a_cs),
  .a_wr        (a_wr),
  .a_en        (a_en),
  .a_mbx       (a_mbx),
  .a_rdata     (a_rdata),
  .a_ab_flag_n (a_ab_flag_n),
  .a_ba_flag_n (a_ba_flag_n),
  .clk_b       (clk_b),
  .rst_b       (rst_b),
  .b_cs        (b_cs),
  .b_wr        (b_wr),
  .b_en        (b_en),
  .b_mbx       (b_mbx),
  .b_rdata     (b_rdata),
  .b_ab_flag_n (b_ab_flag_n),
  .b_ba_flag_n (b_ba_flag_n)
);

// File: tb/test_dual_mailbox.sv
module test_dual_mailbox;
  localparam int W = 32;

  logic clk_a = 1'b0, clk_b = 1'b0;
  logic rst_a = 1'b1, rst_b = 1'b1;
  logic a_cs = 0, a_wr = 0, a_en = 0, a_mbx = 0;
  logic b_cs = 0, b_wr = 0, b_en = 0, b_mbx = 0;
  logic [W-1:0] a_wdata = '0, b_wdata = '0;
  logic [W-1:0] a_rdata, b_rdata;
  logic a_ab_flag_n, a_ba_flag_n, b_ab_flag_n, b_ba_flag_n;

  int errs = 0;
  int checks = 0;
  bit done = 0;
  logic [W-1:0] exp_q[$];

  always #10 clk_a = ~clk_a;
  initial begin
    #7;
    forever #10 clk_b = ~clk_b;
  end

  dual_mailbox #(.DATA_W(W)) i_dual_mailbox (
    .clk_a(clk_a), .rst_a(rst_a), .a_cs(a_cs), .a_wr(a_wr), .a_en(a_en),
    .a_mbx(a_mbx), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .a_ab_flag_n(a_ab_flag_n), .a_ba_flag_n(a_ba_flag_n),
    .clk_b(clk_b), .rst_b(rst_b), .b_cs(b_cs), .b_wr(b_wr), .b_en(b_en),
    .b_mbx(b_mbx), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .b_ab_flag_n(b_ab_flag_n), .b_ba_flag_n(b_ba_flag_n)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic a_op(input logic cs, wr, en, mbx, input logic [W-1:0] d);
    @(negedge clk_a);
    a_cs = cs; a_wr = wr; a_en = en; a_mbx = mbx; a_wdata = d;
    @(negedge clk_a);
    a_cs = 0; a_wr = 0; a_en = 0; a_mbx = 0;
  endtask

  task automatic b_op(input logic cs, wr, en, mbx, input logic [W-1:0] d);
    @(negedge clk_b);
    b_cs = cs; b_wr = wr; b_en = en; b_mbx = mbx; b_wdata = d;
    @(negedge clk_b);
    b_cs = 0; b_wr = 0; b_en = 0; b_mbx = 0;
  endtask

  function automatic logic cur_flag(input int which);
    case (which)
      0: return a_ab_flag_n;
      1: return b_ab_flag_n;
      2: return b_ba_flag_n;
      default: return a_ba_flag_n;
    endcase
  endfunction

  // 0/3 are in the A domain, 1/2 in the B domain
  task automatic wait_flag(input int which, input logic val, input int maxc, output int cyc);
    cyc = 0;
    while (cur_flag(which) !== val && cyc < maxc) begin
      if (which == 0 || which == 3) @(negedge clk_a);
      else @(negedge clk_b);
      cyc++;
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    int cyc;
    repeat (6) @(negedge clk_a);
    // R1: reset state
    chk("R1 a_ab", a_ab_flag_n, 1); chk("R1 a_ba", a_ba_flag_n, 1);
    chk("R1 b_ab", b_ab_flag_n, 1); chk("R1 b_ba", b_ba_flag_n, 1);
    chk("R1 a_rdata", a_rdata, 0);  chk("R1 b_rdata", b_rdata, 0);
    rst_a = 0; rst_b = 0;
    repeat (2) @(negedge clk_a);

    // R4: incomplete writes
    a_op(1, 1, 1, 0, 32'h1111_0001); chk("R4 no mbx", a_ab_flag_n, 1);
    a_op(1, 1, 0, 1, 32'h1111_0002); chk("R4 no en", a_ab_flag_n, 1);
    a_op(0, 1, 1, 1, 32'h1111_0003); chk("R4 no cs", a_ab_flag_n, 1);
    repeat (6) @(negedge clk_b);
    chk("R4 reader idle", b_ab_flag_n, 1);

    // R8: take with nothing pending
    b_op(1, 0, 1, 1, '0);
    chk("R8 reader flag", b_ab_flag_n, 1);
    repeat (6) @(negedge clk_a);
    chk("R8 writer flag", a_ab_flag_n, 1);

    // R2: store
    a_op(1, 1, 1, 1, 32'hCAFE_0001);
    chk("R2 writer flag low", a_ab_flag_n, 0);
    // R5: reader sees mail within four edges
    wait_flag(1, 0, 8, cyc);
    chk("R5 reader flag low", b_ab_flag_n, 0);
    chk("R5 latency<=4", (cyc <= 4), 1);

    // R3: write while pending ignored
    a_op(1, 1, 1, 1, 32'hDEAD_0002);
    chk("R3 writer flag", a_ab_flag_n, 0);

    // R7 / R10: view without en, twice
    @(negedge clk_b);
    b_cs = 1; b_wr = 0; b_en = 0; b_mbx = 1;
    @(negedge clk_b);
    chk("R7 view word", b_rdata, 32'hCAFE_0001);
    @(negedge clk_b);
    chk("R10 stable view", b_rdata, 32'hCAFE_0001);
    b_cs = 0; b_mbx = 0;
    @(negedge clk_b);
    chk("R7 zero when not viewed", b_rdata, 0);
    chk("R7 view kept mail", b_ab_flag_n, 0);
    b_op(1, 0, 1, 0, '0);
    chk("R7 mbx low zero", b_rdata, 0);
    chk("R7 mbx low no take", b_ab_flag_n, 0);

    // R9: reverse direction while A-to-B is pending
    b_op(1, 1, 1, 1, 32'hBEEF_0003);
    chk("R9 b writer low", b_ba_flag_n, 0);
    wait_flag(3, 0, 8, cyc);
    chk("R9 a reader low", a_ba_flag_n, 0);
    a_op(1, 0, 1, 1, '0);
    chk("R9 a rdata", a_rdata, 32'hBEEF_0003);
    chk("R9 a reader high", a_ba_flag_n, 1);
    wait_flag(2, 1, 8, cyc);
    chk("R9 b writer high", b_ba_flag_n, 1);
    chk("R9 ab untouched", b_ab_flag_n, 0);
    chk("R9 ab writer untouched", a_ab_flag_n, 0);

    // R6: take
    b_op(1, 0, 1, 1, '0);
    chk("R6 take word (R3 kept first)", b_rdata, 32'hCAFE_0001);
    chk("R6 reader flag high", b_ab_flag_n, 1);
    wait_flag(0, 1, 8, cyc);
    chk("R6 writer flag high", a_ab_flag_n, 1);
    chk("R6 writer latency<=4", (cyc <= 4), 1);

    // R2/R6 scoreboard stream
    fork
      begin : drv
        for (int i = 0; i < 10; i++) begin
          int c;
          wait_flag(0, 1, 20, c);
          if (c >= 20) chk("R6 writer ready", a_ab_flag_n, 1);
          exp_q.push_back(32'h5A00_0000 + i * 32'h0101);
          a_op(1, 1, 1, 1, 32'h5A00_0000 + i * 32'h0101);
        end
      end
      begin : mon
        for (int i = 0; i < 10; i++) begin
          int c;
          logic [W-1:0] e;
          wait_flag(1, 0, 20, c);
          chk("R5 stream arrival", b_ab_flag_n, 0);
          b_op(1, 0, 1, 1, '0);
          e = (exp_q.size() > 0) ? exp_q.pop_front() : 'x;
          chk("R6 stream word", b_rdata, e);
        end
      end
    join

    done = 1;
    summary();
    $finish;
  end
endmodule